// File: doc/BRIEF.md
# Remote Reconfiguration Control Register Unit

This unit is the host-facing register file that governs remote reconfiguration of a programmable device. A host issues single-cycle read or write strobes, a 3-bit parameter code and a 2-bit source select. The unit holds the live control settings: the boot page address, the watchdog enable and a 12-bit watchdog timeout. Every strobe it accepts keeps `busy` high for a fixed number of cycles. Read results are registered on `rd_data`.

Each reconfiguration event pushes a snapshot of the live settings into a short history. The event is either a host-signalled switch between the factory image and an application image, or a watchdog expiry. Source select 0 addresses the live settings and the non-zero selects address the saved snapshots. A watchdog down-counter takes the 12-bit timeout as its upper bits. A service pulse restarts it. If it runs out while enabled, the unit raises a one-cycle timeout pulse, drops back to factory mode and records the watchdog as the cause.

Top module: `rcfg_ctrl`

## Requirements
- R1: After reset, the unit reads mode 0 (factory), cause 0, watchdog enable 0, timeout DEF_TIMEOUT and page DEF_PAGE. All history entries read as zero, and `busy`, `rd_data` and `wd_timeout` are low.
- R2: A strobe seen while `busy` is low is accepted. `busy` is then high for exactly BUSY_CYCLES cycles, starting in the cycle after the strobe. Strobes that arrive while `busy` is high are ignored.
- R3: An accepted read latches the selected value into `rd_data`, zero-extended. Code 3'b010 gives the 12-bit timeout, code 3'b011 gives the enable in bit 0, and code 3'b100 gives the 32-bit page. `rd_data` holds this value until the next accepted read.
- R4: Code 3'b000 reads the mode: 0 is factory and 1 is application. Code 3'b001 reads the cause of the last reconfiguration: 0 none, 1 host switch, 2 watchdog expiry.
- R5: An accepted write with source 2'b00 updates code 3'b010 from `wr_data[11:0]`, code 3'b011 from `wr_data[0]` and code 3'b100 from `wr_data[31:0]`. Writes to codes 3'b000, 3'b001 and 3'b101 to 3'b111 change nothing.
- R6: A write with a source select other than 2'b00 changes no register.
- R7: When both strobes are accepted together, the unit performs only the write, and `rd_data` keeps its previous value.
- R8: A `cfg_req` pulse pushes the live settings into history and ages the older entries by one. The unit then sets the mode to `cfg_app` and the cause to 1. Source 2'b01 reads the newest entry, 2'b10 the next and 2'b11 the oldest.
- R9: The watchdog counter loads {timeout, WD_LOW_BITS zeros} on a `wd_kick`, on an accepted write to code 3'b010 or 3'b011, and on any reconfiguration. It counts down while enabled. With an undisturbed count of L, `wd_timeout` goes high for exactly one cycle after the (L+1)th clock edge that follows the loading edge.
- R10: A watchdog expiry pushes history, sets mode 0 and cause 2, and clears the enable. If a `cfg_req` arrives in the same cycle, the expiry wins and only one entry is pushed.
- R11: `wd_kick` alters no readable register.
- R12: Reads of codes 3'b101 to 3'b111 return zero from any source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| rd_strobe | input | 1 | Read request pulse |
| wr_strobe | input | 1 | Write request pulse |
| par_sel | input | 3 | Parameter code |
| src_sel | input | 2 | 0 selects the live settings; 1 to 3 select history entries |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read result |
| busy | output | 1 | High while an accepted access is in progress |
| cfg_req | input | 1 | Reconfiguration event pulse |
| cfg_app | input | 1 | Target of the event: 1 application, 0 factory |
| wd_kick | input | 1 | Watchdog service pulse |
| wd_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
A strobe is sampled on one edge, and `busy` is checked at the next BUSY_CYCLES falling edges and must then be low. Read data is compared at the first falling edge where `busy` is low again, which is the earliest cycle in which it is valid. The expiry pulse is due L+1 edges after the edge that loaded the counter. The bench counts falling edges from that load and requires the pulse at exactly that count and its absence one cycle later. In the priority test, the reconfiguration request is driven so that it lands on the same edge as the expiry.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    localparam int TO_W   = 12;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    localparam logic [2:0] PAR_MODE  = 3'b000;
    localparam logic [2:0] PAR_CAUSE = 3'b001;
    localparam logic [2:0] PAR_WDTO  = 3'b010;
    localparam logic [2:0] PAR_WDEN  = 3'b011;
    localparam logic [2:0] PAR_PAGE  = 3'b100;

    localparam logic [1:0] SRC_LIVE = 2'b00;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_HOST = 2'd1,
        CAUSE_WDOG = 2'd2
    } cause_e;

    typedef struct packed {
        cause_e              cause;
        logic                app_mode;
        logic                wd_en;
        logic [TO_W-1:0]     wd_to;
        logic [ADDR_W-1:0]   page;
    } snap_t;

    // Zero-extended view of one field of a settings snapshot.
    function automatic logic [DATA_W-1:0] snap_field(input snap_t s, input logic [2:0] code);
        logic [DATA_W-1:0] v;
        v = '0;
        case (code)
            PAR_MODE:  v = DATA_W'(s.app_mode);
            PAR_CAUSE: v = DATA_W'(s.cause);
            PAR_WDTO:  v = DATA_W'(s.wd_to);
            PAR_WDEN:  v = DATA_W'(s.wd_en);
            PAR_PAGE:  v = DATA_W'(s.page);
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rcfg_busy.sv
module rcfg_busy #(
    parameter int BUSY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    output logic busy,
    output logic accept
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } bsy_t;

    bsy_t st_d, st_q;

    assign busy   = (st_q.cnt != '0);
    assign accept = !busy && (rd_req || wr_req);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.cnt = CW'(BUSY_CYCLES);
        end else if (busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rcfg_wdog.sv
module rcfg_wdog #(
    parameter int TO_BITS  = 12,
    parameter int LOW_BITS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reload,
    input  logic [TO_BITS-1:0] to_val,
    input  logic               run,
    output logic               expire
);
    localparam int CNT_W = TO_BITS + LOW_BITS;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wd_t;

    wd_t st_d, st_q;

    // Independent of reload so that the parent may feed expiry back into reload.
    assign expire = run && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.cnt = {to_val, {LOW_BITS{1'b0}}};
        end else if (run && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rcfg_hist.sv
module rcfg_hist
    import rcfg_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  snap_t                 snap_in,
    output snap_t [DEPTH-1:0]     ent
);
    snap_t [DEPTH-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (push) begin
            ent_d[0] = snap_in;
            for (int i = 1; i < DEPTH; i++) begin
                ent_d[i] = ent_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ent = ent_q;

endmodule

// File: rtl/rcfg_ctrl.sv
module rcfg_ctrl
    import rcfg_pkg::*;
#(
    parameter int              BUSY_CYCLES = 3,
    parameter int              HIST_DEPTH  = 3,
    parameter int              WD_LOW_BITS = 4,
    parameter logic [TO_W-1:0] DEF_TIMEOUT = 12'h010,
    parameter logic [ADDR_W-1:0] DEF_PAGE  = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic [2:0]        par_sel,
    input  logic [1:0]        src_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    input  logic              cfg_req,
    input  logic              cfg_app,
    input  logic              wd_kick,
    output logic              wd_timeout
);
    typedef struct packed {
        snap_t             cur;
        logic [DATA_W-1:0] rd;
        logic              tout;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                  accept;
    logic                  busy_w;
    logic                  expire;
    logic                  wd_reload;
    logic                  hist_push;
    logic                  wr_ok;
    snap_t                 sel_snap;
    snap_t [HIST_DEPTH-1:0] hist;

    rcfg_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst    (rst),
        .rd_req (rd_strobe),
        .wr_req (wr_strobe),
        .busy   (busy_w),
        .accept (accept)
    );

    rcfg_wdog #(.TO_BITS(TO_W), .LOW_BITS(WD_LOW_BITS)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .reload (wd_reload),
        .to_val (st_d.cur.wd_to),
        .run    (st_q.cur.wd_en),
        .expire (expire)
    );

    rcfg_hist #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .push    (hist_push),
        .snap_in (st_q.cur),
        .ent     (hist)
    );

    // Snapshot addressed by the source select.
    always_comb begin
        sel_snap = '0;
        if (src_sel == SRC_LIVE) begin
            sel_snap = st_q.cur;
        end
        for (int i = 0; i < HIST_DEPTH; i++) begin
            if (int'(src_sel) == i + 1) begin
                sel_snap = hist[i];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tout = 1'b0;
        hist_push = 1'b0;
        wr_ok     = accept && wr_strobe && (src_sel == SRC_LIVE);

        if (wr_ok) begin
            case (par_sel)
                PAR_WDTO: st_d.cur.wd_to = wr_data[TO_W-1:0];
                PAR_WDEN: st_d.cur.wd_en = wr_data[0];
                PAR_PAGE: st_d.cur.page  = wr_data[ADDR_W-1:0];
                default:  ;
            endcase
        end

        if (accept && !wr_strobe) begin
            st_d.rd = snap_field(sel_snap, par_sel);
        end

        if (expire) begin
            hist_push         = 1'b1;
            st_d.cur.app_mode = 1'b0;
            st_d.cur.wd_en    = 1'b0;
            st_d.cur.cause    = CAUSE_WDOG;
            st_d.tout         = 1'b1;
        end else if (cfg_req) begin
            hist_push         = 1'b1;
            st_d.cur.app_mode = cfg_app;
            st_d.cur.cause    = CAUSE_HOST;
        end

        wd_reload = wd_kick || cfg_req || expire ||
                    (wr_ok && ((par_sel == PAR_WDTO) || (par_sel == PAR_WDEN)));
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.cur.cause    <= CAUSE_NONE;
            st_q.cur.app_mode <= 1'b0;
            st_q.cur.wd_en    <= 1'b0;
            st_q.cur.wd_to    <= DEF_TIMEOUT;
            st_q.cur.page     <= DEF_PAGE;
            st_q.rd           <= '0;
            st_q.tout         <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rd;
    assign busy       = busy_w;
    assign wd_timeout = st_q.tout;

endmodule

// File: rtl/rcfg_ctrl_chk.sv
module rcfg_ctrl_chk #(
    parameter int BUSY_CYCLES = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_strobe,
    input logic        wr_strobe,
    input logic [1:0]  src_sel,
    input logic        busy,
    input logic [31:0] rd_data,
    input logic        wd_timeout,
    input logic        wd_kick,
    input logic        cur_mode,
    input logic        cur_en,
    input logic [31:0] cur_page,
    input logic [11:0] cur_to
);
    localparam int RW = $clog2(BUSY_CYCLES + 2);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R2: an accepted strobe raises busy on the next cycle
    a_r2_busy_rises: assert property (@(posedge clk) disable iff (rst)
        (!busy && (rd_strobe || wr_strobe)) |=> busy);

    // R2: busy never lasts longer than BUSY_CYCLES
    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(run_len) < BUSY_CYCLES));

    // R3: read data cannot move while an access is in progress
    a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_data));

    // R6: writes aimed at a history source leave the live settings alone
    a_r6_src_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !busy && (src_sel != 2'b00)) |=> ($stable(cur_page) && $stable(cur_to)));

    // R9: the expiry pulse lasts one cycle
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        wd_timeout |=> !wd_timeout);

    // R10: expiry leaves the unit in factory mode with the watchdog off
    a_r10_tout_factory: assert property (@(posedge clk) disable iff (rst)
        wd_timeout |-> (!cur_mode && !cur_en));

    // R11: servicing the watchdog leaves the settings untouched
    a_r11_kick_keeps: assert property (@(posedge clk) disable iff (rst)
        (wd_kick && !(wr_strobe && !busy)) |=> ($stable(cur_page) && $stable(cur_to)));

endmodule

bind rcfg_ctrl rcfg_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .src_sel    (src_sel),
    .busy       (busy),
    .rd_data    (rd_data),
    .wd_timeout (wd_timeout),
    .wd_kick    (wd_kick),
    .cur_mode   (st_q.cur.app_mode),
    .cur_en     (st_q.cur.wd_en),
    .cur_page   (st_q.cur.page),
    .cur_to     (st_q.cur.wd_to)
);

// File: tb/tb_rcfg_ctrl.sv
module tb_rcfg_ctrl;
    import rcfg_pkg::*;

    localparam int          B      = 3;
    localparam int          DEPTH  = 3;
    localparam int          LOW    = 4;
    localparam logic [11:0] DEF_TO = 12'h010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_strobe = 1'b0, wr_strobe = 1'b0;
    logic [2:0]  par_sel = '0;
    logic [1:0]  src_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic        cfg_req = 1'b0, cfg_app = 1'b0, wd_kick = 1'b0;
    logic        wd_timeout;

    int checks = 0;
    int fails  = 0;

    snap_t m_cur;
    snap_t m_hist [DEPTH];

    always #4 clk = ~clk;

    rcfg_ctrl #(.BUSY_CYCLES(B), .HIST_DEPTH(DEPTH), .WD_LOW_BITS(LOW),
                .DEF_TIMEOUT(DEF_TO), .DEF_PAGE(32'h0)) dut (
        .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .par_sel(par_sel), .src_sel(src_sel), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .cfg_req(cfg_req), .cfg_app(cfg_app), .wd_kick(wd_kick),
        .wd_timeout(wd_timeout)
    );

    function automatic logic [31:0] field_of(snap_t s, logic [2:0] code);
        case (code)
            3'd0:    return {31'b0, s.app_mode};
            3'd1:    return {30'b0, s.cause};
            3'd2:    return {20'b0, s.wd_to};
            3'd3:    return {31'b0, s.wd_en};
            3'd4:    return s.page;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] expect_read(logic [1:0] src, logic [2:0] code);
        if (src == 2'b00) return field_of(m_cur, code);
        return field_of(m_hist[int'(src) - 1], code);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_push(cause_e c, logic mode, logic clr_en);
        for (int i = DEPTH - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = m_cur;
        m_cur.cause = c;
        m_cur.app_mode = mode;
        if (clr_en) m_cur.wd_en = 1'b0;
    endtask

    // One access; returns at the first falling edge with busy low again.
    task automatic access(logic r, logic w, logic [2:0] p, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        rd_strobe = r; wr_strobe = w; par_sel = p; src_sel = s; wr_data = d;
        @(negedge clk);
        rd_strobe = 1'b0; wr_strobe = 1'b0;
        repeat (B) @(negedge clk);
        if (w && s == 2'b00) begin
            case (p)
                3'd2: m_cur.wd_to = d[11:0];
                3'd3: m_cur.wd_en = d[0];
                3'd4: m_cur.page  = d;
                default: ;
            endcase
        end
    endtask

    task automatic read_chk(logic [2:0] p, logic [1:0] s, string tag);
        access(1'b1, 1'b0, p, s, 32'h0);
        chk(tag, rd_data, expect_read(s, p));
    endtask

    task automatic do_switch(logic app);
        @(negedge clk);
        cfg_req = 1'b1; cfg_app = app;
        @(negedge clk);
        cfg_req = 1'b0;
        model_push(CAUSE_HOST, app, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] first;
        void'($urandom(32'd20240611));
        m_cur = '0;
        m_cur.wd_to = DEF_TO;
        for (int i = 0; i < DEPTH; i++) m_hist[i] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 wd_timeout", {31'b0, wd_timeout}, 32'h0);
        for (int c = 0; c < 5; c++) read_chk(3'(c), 2'b00, "R1 live field");
        for (int c = 0; c < 5; c++) read_chk(3'(c), 2'b01, "R1 history field");

        // R2 busy window and strobe during busy ignored
        @(negedge clk);
        wr_strobe = 1'b1; par_sel = 3'd4; src_sel = 2'b00; wr_data = 32'hA5A5_0001;
        @(negedge clk);
        chk("R2 busy first cycle", {31'b0, busy}, 32'h1);
        wr_data = 32'h1234_5678;
        @(negedge clk);
        wr_strobe = 1'b0;
        for (int i = 1; i < B; i++) begin
            chk("R2 busy held", {31'b0, busy}, 32'h1);
            if (i < B - 1) @(negedge clk);
        end
        @(negedge clk);
        chk("R2 busy released", {31'b0, busy}, 32'h0);
        m_cur.page = 32'hA5A5_0001;
        read_chk(3'd4, 2'b00, "R2 ignored strobe left page");

        // R3 / R5 directed writes and reads
        access(1'b0, 1'b1, 3'd2, 2'b00, 32'hFFFF_F3A7);
        read_chk(3'd2, 2'b00, "R3 R5 timeout zero-extended");
        access(1'b0, 1'b1, 3'd4, 2'b00, 32'hDEAD_BEEF);
        read_chk(3'd4, 2'b00, "R3 R5 page");
        access(1'b0, 1'b1, 3'd3, 2'b00, 32'hFFFF_FFFE);
        read_chk(3'd3, 2'b00, "R3 R5 enable bit 0");
        // R3 hold until next read
        repeat (5) @(negedge clk);
        chk("R3 rd_data held", rd_data, 32'h0);

        // R5 read-only and unused codes
        access(1'b0, 1'b1, 3'd0, 2'b00, 32'h1);
        read_chk(3'd0, 2'b00, "R5 mode not writable");
        access(1'b0, 1'b1, 3'd1, 2'b00, 32'h3);
        read_chk(3'd1, 2'b00, "R5 cause not writable");
        access(1'b0, 1'b1, 3'd5, 2'b00, 32'hFFFF_FFFF);
        // R12 unused codes
        for (int c = 5; c < 8; c++) read_chk(3'(c), 2'b00, "R12 unused code");

        // R6 write with history source
        access(1'b0, 1'b1, 3'd4, 2'b10, 32'h0BAD_0BAD);
        read_chk(3'd4, 2'b00, "R6 history-source write ignored");

        // R7 simultaneous strobes
        read_chk(3'd4, 2'b00, "R7 prime");
        first = rd_data;
        access(1'b1, 1'b1, 3'd2, 2'b00, 32'h0000_0ABC);
        chk("R7 rd_data unchanged", rd_data, first);
        read_chk(3'd2, 2'b00, "R7 write performed");

        // R8 history
        do_switch(1'b1);
        access(1'b0, 1'b1, 3'd4, 2'b00, 32'h0000_1000);
        do_switch(1'b0);
        do_switch(1'b1);
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 5; c++) read_chk(3'(c), 2'(s), "R4 R8 history readback");

        // R11 kick disturbs nothing
        @(negedge clk); wd_kick = 1'b1;
        @(negedge clk); wd_kick = 1'b0;
        for (int c = 0; c < 5; c++) read_chk(3'(c), 2'b00, "R11 kick keeps settings");

        // Random mix (watchdog kept disabled)
        for (int k = 0; k < 300; k++) begin
            int op;
            logic [2:0] p;
            logic [1:0] s;
            logic [31:0] d;
            op = int'($urandom % 4);
            p  = 3'($urandom);
            s  = 2'($urandom);
            d  = $urandom;
            if (op == 0) begin
                read_chk(p, s, (s == 2'b00) ? "R3 random read" : "R8 random history read");
            end else if (op == 3) begin
                do_switch(d[5]);
            end else begin
                if (p == 3'd3) d[0] = 1'b0;
                if (d[7]) s = 2'b00;
                access(1'b0, 1'b1, p, s, d);
            end
        end

        // R9 watchdog timing
        access(1'b0, 1'b1, 3'd2, 2'b00, 32'h3);
        access(1'b0, 1'b1, 3'd3, 2'b00, 32'h1);
        do_switch(1'b1);
        @(negedge clk); wd_kick = 1'b1;
        @(negedge clk); wd_kick = 1'b0;
        n = 0;
        while (n < 400) begin
            @(negedge clk);
            n++;
            if (wd_timeout) break;
        end
        chk("R9 expiry edge count", 32'(n), 32'((3 << LOW) + 1));
        @(negedge clk);
        chk("R9 pulse one cycle", {31'b0, wd_timeout}, 32'h0);
        model_push(CAUSE_WDOG, 1'b0, 1'b1);
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 5; c++) read_chk(3'(c), 2'(s), "R10 expiry state");

        // R10 priority over a simultaneous request
        access(1'b0, 1'b1, 3'd3, 2'b00, 32'h1);
        @(negedge clk); wd_kick = 1'b1;
        @(negedge clk); wd_kick = 1'b0;
        for (int i = 0; i < (3 << LOW); i++) @(negedge clk);
        cfg_req = 1'b1; cfg_app = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
        chk("R10 expiry coincides", {31'b0, wd_timeout}, 32'h1);
        model_push(CAUSE_WDOG, 1'b0, 1'b1);
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 5; c++) read_chk(3'(c), 2'(s), "R10 priority state");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule